// File: doc/BRIEF.md
# Multichannel Round-Robin DMA Engine

This block is a small bus master that copies data from one slave location to another without a processor moving each word. It keeps several channels. Each channel has its own programmed transfer settings and its own working context: current source and destination, elements left, and a pacing counter. One shared datapath serves all channels. Each time it is free it picks the next eligible channel in round-robin order, reads one element from that channel's source, waits for the read response, writes the returned word to the channel's destination, and then moves the channel's context forward.

Software programs each channel through a word-wide register port and starts it by setting its enable bit. A channel stops and raises a sticky done flag when its count runs out, unless its loop bit is set. With the loop bit set it rewinds to its start addresses and runs until software clears the enable bit. The read request and the read response are separate handshakes, so any memory latency and any back-pressure can be absorbed. A per-channel rate setting slows a channel that feeds a slow peripheral.

Top module: `dma_engine`

## Requirements
- R1: After synchronous reset, `rd_req_valid`, `wr_valid` and every `done_o` bit are 0, and every channel's status register reads 0.
- R2: Each grant moves one element. It issues a read at the channel's current source, then a write of exactly the returned data to the channel's current destination. Both carry the channel's size code (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes).
- R3: After each element, both current addresses advance by stride shifted left by log2 of the element size in bytes. A stride of 0 keeps both addresses fixed.
- R4: A channel without loop performs exactly COUNT elements. It then sets its done flag (status bit 0 and `done_o`) and clears its enable bit (status bit 1).
- R5: The done flag stays set until software writes the status register with bit 0 = 1.
- R6: With loop set, a channel that finishes its last element reloads its programmed source, destination and count, keeps done clear, and continues. It stops only after software writes enable = 0, with at most the element already in flight still completed.
- R7: After a write handshake, a channel is not granted again until RATE further cycles have passed. With a single active channel, ready memory and a one-cycle read response, consecutive writes are RATE+4 cycles apart.
- R8: Among eligible channels (enabled, pacing counter expired), the grant goes to the first one found when searching cyclically from the channel after the one last served. This holds even if the last-served channel is still eligible.
- R9: While a channel is enabled, writes to its source, destination, stride and count registers, and to the control fields other than enable, are ignored. The programmed values are copied into the working context when enable goes from 0 to 1.
- R10: A valid request holds its address (and its data, for a write) until ready. The read response may arrive any number of cycles later. At most one element is in flight, so a read request and a write are never valid together.
- R11: Enabling a channel whose programmed count is 0 sets its done flag at once, clears enable, and moves no data.
- R12: `cfg_addr` is {channel, register[2:0]}. The register codes are: 0 source, 1 destination, 2 stride, 3 count, 4 control (bit 0 enable, bit 1 loop, bits 3:2 size code, bits 15:8 rate), and 5 status (bit 0 done, bit 1 enable, bits 31:16 elements remaining). Reads of codes 0 to 4 return the programmed values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | log2(NCH)+3 | {channel, register code} |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| done_o | output | NCH | Per-channel sticky done flags |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Read byte address |
| rd_req_size | output | 2 | Read element size code |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 32 | Read response data |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| wr_size | output | 2 | Write element size code |

## Verification
The bench goes after the pacing gap, the stride-times-size step for every size code, a zero stride, and a size code of 3. A design that paced from the wrong edge, or scaled the step wrongly, puts writes at the wrong spacing or the wrong address. The pointer test stalls a write so that three channels become eligible together, and expects the channel after the one just served to win. A fixed-priority arbiter, or one that does not advance its pointer, serves the wrong channel next. Further tests cover a configuration write made while the channel runs, a zero count, loop rewind followed by disable, and long read latency with toggling ready. Each of these catches, in turn: a design that lets a running transfer be corrupted, one that underflows its count, one that raises done in loop mode, and one that drops or duplicates data under stalls.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int REG_W  = 32;

    localparam logic [2:0] REG_SRC    = 3'd0;
    localparam logic [2:0] REG_DST    = 3'd1;
    localparam logic [2:0] REG_STRIDE = 3'd2;
    localparam logic [2:0] REG_COUNT  = 3'd3;
    localparam logic [2:0] REG_CTRL   = 3'd4;
    localparam logic [2:0] REG_STATUS = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WAIT = 2'd2,
        ST_WR   = 2'd3
    } eng_state_e;

    // One element's worth of addressing, captured at grant time
    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [1:0]        size;
    } xfer_t;

    // log2 of the element size in bytes; code 3 is treated as 4 bytes
    function automatic logic [1:0] size_shift(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction
endpackage

// File: rtl/dma_rr_arb.sv
module dma_rr_arb
    import dma_pkg::*;
#(
    parameter int NCH  = 4,
    localparam int CH_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]  req,
    input  logic [CH_W-1:0] ptr,
    output logic            any,
    output logic [CH_W-1:0] gnt
);
    // Walk backwards so the smallest offset from ptr wins
    always_comb begin
        any = 1'b0;
        gnt = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[(int'(ptr) + i) % NCH]) begin
                any = 1'b1;
                gnt = CH_W'((int'(ptr) + i) % NCH);
            end
        end
    end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int RATE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_reg,
    input  logic [REG_W-1:0] wr_data,
    input  logic [2:0]       rd_reg,
    input  logic             adv,
    output logic             eligible,
    output xfer_t            cur,
    output logic [REG_W-1:0] rd_data,
    output logic             done
);
    logic [ADDR_W-1:0] src_q, dst_q, stride_q, cur_src_q, cur_dst_q;
    logic [CNT_W-1:0]  cnt_q, rem_q;
    logic [RATE_W-1:0] rate_q, gap_q;
    logic [1:0]        size_q;
    logic              loop_q, en_q, done_q;
    logic [ADDR_W-1:0] step;

    assign step     = stride_q << size_shift(size_q);
    assign eligible = en_q && (gap_q == '0);
    assign done     = done_q;
    assign cur      = '{src: cur_src_q, dst: cur_dst_q, size: size_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0; dst_q <= '0; stride_q <= '0; cnt_q <= '0;
            cur_src_q <= '0; cur_dst_q <= '0; rem_q <= '0;
            rate_q <= '0; gap_q <= '0; size_q <= '0;
            loop_q <= 1'b0; en_q <= 1'b0; done_q <= 1'b0;
        end else begin
            if (gap_q != '0) gap_q <= gap_q - 1'b1;
            if (wr_en) begin
                case (wr_reg)
                    REG_SRC:    if (!en_q) src_q <= wr_data;
                    REG_DST:    if (!en_q) dst_q <= wr_data;
                    REG_STRIDE: if (!en_q) stride_q <= wr_data;
                    REG_COUNT:  if (!en_q) cnt_q <= wr_data[CNT_W-1:0];
                    REG_CTRL: begin
                        en_q <= wr_data[0];
                        if (!en_q) begin
                            loop_q <= wr_data[1];
                            size_q <= wr_data[3:2];
                            rate_q <= wr_data[8 +: RATE_W];
                            if (wr_data[0]) begin
                                cur_src_q <= src_q;
                                cur_dst_q <= dst_q;
                                rem_q     <= cnt_q;
                                gap_q     <= '0;
                                if (cnt_q == '0) begin
                                    en_q   <= 1'b0;
                                    done_q <= 1'b1;
                                end
                            end
                        end
                    end
                    REG_STATUS: if (wr_data[0]) done_q <= 1'b0;
                    default: ;
                endcase
            end
            if (adv) begin
                gap_q <= rate_q;
                if (rem_q <= CNT_W'(1)) begin
                    if (loop_q) begin
                        cur_src_q <= src_q;
                        cur_dst_q <= dst_q;
                        rem_q     <= cnt_q;
                    end else begin
                        rem_q  <= '0;
                        en_q   <= 1'b0;
                        done_q <= 1'b1;
                    end
                end else begin
                    rem_q     <= rem_q - 1'b1;
                    cur_src_q <= cur_src_q + step;
                    cur_dst_q <= cur_dst_q + step;
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_reg)
            REG_SRC:    rd_data = src_q;
            REG_DST:    rd_data = dst_q;
            REG_STRIDE: rd_data = stride_q;
            REG_COUNT:  rd_data[CNT_W-1:0] = cnt_q;
            REG_CTRL: begin
                rd_data[0]            = en_q;
                rd_data[1]            = loop_q;
                rd_data[3:2]          = size_q;
                rd_data[8 +: RATE_W]  = rate_q;
            end
            REG_STATUS: begin
                rd_data[0]            = done_q;
                rd_data[1]            = en_q;
                rd_data[16 +: CNT_W]  = rem_q;
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int RATE_W = 8,
    localparam int CH_W  = $clog2(NCH),
    localparam int CA_W  = CH_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CA_W-1:0]   cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic [NCH-1:0]    done_o,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_req_addr,
    output logic [1:0]        rd_req_size,
    input  logic              rd_rsp_valid,
    input  logic [DATA_W-1:0] rd_rsp_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [1:0]        wr_size
);
    eng_state_e        state_q;
    logic [CH_W-1:0]   gnt_q, ptr_q, arb_gnt;
    logic              arb_any;
    xfer_t             elem_q;
    logic [DATA_W-1:0] data_q;
    logic [NCH-1:0]    elig;
    xfer_t             ctx [NCH];
    logic [REG_W-1:0]  rdv [NCH];
    logic              wr_fire;

    assign wr_fire = (state_q == ST_WR) && wr_ready;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dma_chan #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (cfg_we && (cfg_addr[CA_W-1:3] == CH_W'(c))),
            .wr_reg   (cfg_addr[2:0]),
            .wr_data  (cfg_wdata),
            .rd_reg   (cfg_addr[2:0]),
            .adv      (wr_fire && (gnt_q == CH_W'(c))),
            .eligible (elig[c]),
            .cur      (ctx[c]),
            .rd_data  (rdv[c]),
            .done     (done_o[c])
        );
    end

    dma_rr_arb #(.NCH(NCH)) u_arb (
        .req (elig),
        .ptr (ptr_q),
        .any (arb_any),
        .gnt (arb_gnt)
    );

    assign cfg_rdata    = rdv[cfg_addr[CA_W-1:3]];
    assign rd_req_valid = (state_q == ST_RD);
    assign rd_req_addr  = elem_q.src;
    assign rd_req_size  = elem_q.size;
    assign wr_valid     = (state_q == ST_WR);
    assign wr_addr      = elem_q.dst;
    assign wr_data      = data_q;
    assign wr_size      = elem_q.size;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            gnt_q   <= '0;
            ptr_q   <= '0;
            elem_q  <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (arb_any) begin
                    gnt_q   <= arb_gnt;
                    elem_q  <= ctx[arb_gnt];
                    state_q <= ST_RD;
                end
                ST_RD:   if (rd_req_ready) state_q <= ST_WAIT;
                ST_WAIT: if (rd_rsp_valid) begin
                    data_q  <= rd_rsp_data;
                    state_q <= ST_WR;
                end
                ST_WR:   if (wr_ready) begin
                    ptr_q   <= CH_W'((int'(gnt_q) + 1) % NCH);
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
    parameter int NCH  = 4,
    localparam int CH_W = $clog2(NCH),
    localparam int CA_W = CH_W + 3
) (
    input logic            clk,
    input logic            rst,
    input logic            cfg_we,
    input logic [CA_W-1:0] cfg_addr,
    input logic [NCH-1:0]  done_o,
    input logic            rd_req_valid,
    input logic            rd_req_ready,
    input logic [31:0]     rd_req_addr,
    input logic            rd_rsp_valid,
    input logic            wr_valid,
    input logic            wr_ready,
    input logic [31:0]     wr_addr,
    input logic [31:0]     wr_data
);
    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

    assert_wr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    assert_single_flight_R10: assert property (@(posedge clk) disable iff (rst)
        !(rd_req_valid && wr_valid));

    assert_wr_after_rsp_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_valid) |-> $past(rd_rsp_valid));

    for (genvar c = 0; c < NCH; c++) begin : g_done
        assert_done_sticky_R5: assert property (@(posedge clk) disable iff (rst)
            done_o[c] && !(cfg_we && cfg_addr == CA_W'(c * 8 + 5)) |=> done_o[c]);
    end
endmodule

bind dma_engine dma_engine_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/dma_engine_tb.sv
module dma_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [15:0] stride;
        logic [15:0] count;
        logic [1:0]  size;
        logic [7:0]  rate;
        logic [31:0] exp_step;
        logic [7:0]  exp_gap;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h100, 32'h1000, 16'd1, 16'd4, 2'd2, 8'd0,  32'd4,  8'd4},
        '{32'h200, 32'h1000, 16'd1, 16'd3, 2'd0, 8'd0,  32'd1,  8'd4},
        '{32'h300, 32'h1000, 16'd2, 16'd3, 2'd1, 8'd3,  32'd4,  8'd7},
        '{32'h400, 32'h1000, 16'd0, 16'd3, 2'd2, 8'd0,  32'd0,  8'd4},
        '{32'h500, 32'h1000, 16'd3, 16'd2, 2'd3, 8'd10, 32'd12, 8'd14},
        '{32'h580, 32'h1000, 16'd1, 16'd1, 2'd2, 8'd5,  32'd4,  8'd9}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [NCH-1:0] done_o;
    logic        rd_req_valid, rd_req_ready = 1'b1;
    logic [31:0] rd_req_addr;
    logic [1:0]  rd_req_size;
    logic        rd_rsp_valid = 1'b0;
    logic [31:0] rd_rsp_data = '0;
    logic        wr_valid, wr_ready = 1'b1;
    logic [31:0] wr_addr, wr_data;
    logic [1:0]  wr_size;

    dma_engine u_dut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit finished = 0;
    int lat_extra = 0, rsp_cnt = 0, nwr = 0;
    bit stall = 0, wr_hold = 0;
    logic [31:0] pend_addr = '0;
    logic [1:0]  last_rd_size = '0;
    logic [31:0] log_addr [64];
    logic [31:0] log_data [64];
    logic [1:0]  log_sz   [64];
    int          log_cyc  [64];

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, ~a[15:0]};
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Memory model and write logger, all driven at the falling edge
    always @(negedge clk) begin
        rd_req_ready = stall ? cyc[0] : 1'b1;
        wr_ready     = !wr_hold && (stall ? !cyc[0] : 1'b1);
        rd_rsp_valid = 1'b0;
        if (rsp_cnt != 0) begin
            rsp_cnt = rsp_cnt - 1;
            if (rsp_cnt == 0) begin
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = mem_val(pend_addr);
            end
        end
        if (rd_req_valid && rd_req_ready) begin
            pend_addr    = rd_req_addr;
            last_rd_size = rd_req_size;
            rsp_cnt      = 1 + lat_extra;
        end
        if (wr_valid && wr_ready && nwr < 64) begin
            log_addr[nwr] = wr_addr;
            log_data[nwr] = wr_data;
            log_sz[nwr]   = wr_size;
            log_cyc[nwr]  = cyc;
            nwr = nwr + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rsp_cnt = 0; stall = 0; wr_hold = 0; lat_extra = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg_wr(input int ch, input int rg, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(ch * 8 + rg); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input int ch, input int rg, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = 5'(ch * 8 + rg);
        #1 d = cfg_rdata;
    endtask

    task automatic setup(input int ch, input logic [31:0] s, input logic [31:0] dd,
                         input logic [31:0] st, input logic [31:0] cnt);
        cfg_wr(ch, 0, s); cfg_wr(ch, 1, dd); cfg_wr(ch, 2, st); cfg_wr(ch, 3, cnt);
    endtask

    task automatic wait_off(input int ch);
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            cfg_rd(ch, 5, s);
            if (!s[1]) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        do_reset();

        // R1: reset state
        @(negedge clk);
        check(!rd_req_valid && !wr_valid && done_o == '0, "R1 idle outputs",
              {rd_req_valid, wr_valid, 26'd0, done_o}, 32'd0);
        cfg_rd(0, 5, s);
        check(s == 32'd0, "R1 status", s, 32'd0);

        // Vector table: single channel R2 R3 R4 R5 R7 R12
        for (int v = 0; v < 6; v++) begin
            int bad_a, bad_d, bad_s, bad_g;
            bad_a = 0; bad_d = 0; bad_s = 0; bad_g = 0;
            setup(0, VECS[v].src, VECS[v].dst, 32'(VECS[v].stride), 32'(VECS[v].count));
            nwr = 0;
            cfg_wr(0, 4, {16'd0, VECS[v].rate, 4'd0, VECS[v].size, 2'b01});
            wait_off(0);
            check(nwr == int'(VECS[v].count), "R4 element count", 32'(nwr), 32'(VECS[v].count));
            for (int k = 0; k < nwr; k++) begin
                if (log_addr[k] != VECS[v].dst + 32'(k) * VECS[v].exp_step) bad_a++;
                if (log_data[k] != mem_val(VECS[v].src + 32'(k) * VECS[v].exp_step)) bad_d++;
                if (log_sz[k] != VECS[v].size) bad_s++;
                if (k > 0 && log_cyc[k] - log_cyc[k-1] != int'(VECS[v].exp_gap)) bad_g++;
            end
            check(bad_a == 0, "R3 address step", 32'(bad_a), 32'd0);
            check(bad_d == 0 && bad_s == 0 && last_rd_size == VECS[v].size,
                  "R2 data and size", 32'(bad_d + bad_s), 32'd0);
            check(bad_g == 0, "R7 pacing gap", 32'(bad_g), 32'd0);
            cfg_rd(0, 5, s);
            check(s[1:0] == 2'b01 && done_o[0], "R4 done set, enable clear", {30'd0, s[1:0]}, 32'd1);
            repeat (5) @(negedge clk);
            check(done_o[0] == 1'b1, "R5 done holds", {31'd0, done_o[0]}, 32'd1);
            cfg_wr(0, 5, 32'd1);
            cfg_rd(0, 5, s);
            check(s[0] == 1'b0 && !done_o[0], "R5 write-one clears", {31'd0, s[0]}, 32'd0);
        end

        // R9 R12: configuration locked while enabled
        setup(1, 32'h700, 32'h2000, 32'd1, 32'd3);
        nwr = 0;
        cfg_wr(1, 4, {16'd0, 8'd20, 4'd0, 2'd2, 2'b01});
        cfg_wr(1, 0, 32'hDEAD0000);
        cfg_wr(1, 3, 32'd9);
        cfg_wr(1, 2, 32'd5);
        cfg_rd(1, 0, s);
        check(s == 32'h700, "R9 source write ignored", s, 32'h700);
        wait_off(1);
        check(nwr == 3, "R9 count write ignored", 32'(nwr), 32'd3);
        check(nwr >= 3 && log_addr[2] == 32'h2008 && log_data[2] == mem_val(32'h708),
              "R9 context unchanged", log_addr[2], 32'h2008);
        cfg_wr(1, 0, 32'h800);
        cfg_rd(1, 0, s);
        check(s == 32'h800, "R12 source readback when idle", s, 32'h800);
        cfg_wr(1, 5, 32'd1);

        // R11: zero count
        setup(2, 32'h900, 32'h3000, 32'd1, 32'd0);
        nwr = 0;
        cfg_wr(2, 4, 32'h0000_0009);
        cfg_rd(2, 5, s);
        repeat (20) @(negedge clk);
        check(s[1:0] == 2'b01 && nwr == 0, "R11 zero count", {s[1:0], 30'(nwr)}, 32'h4000_0000);
        cfg_wr(2, 5, 32'd1);

        // R8: cyclic order among three channels
        do_reset();
        setup(0, 32'h100, 32'h1000, 32'd1, 32'd4);
        setup(1, 32'h100, 32'h2000, 32'd1, 32'd4);
        setup(3, 32'h100, 32'h4000, 32'd1, 32'd4);
        nwr = 0;
        cfg_wr(0, 4, 32'h9); cfg_wr(1, 4, 32'h9); cfg_wr(3, 4, 32'h9);
        wait_off(0); wait_off(1); wait_off(3);
        check(nwr == 12, "R8 total elements", 32'(nwr), 32'd12);
        begin
            int rem [4];
            int bad, prev;
            rem = '{4, 4, 0, 4};
            bad = 0;
            prev = int'(log_addr[0] >> 12) - 1;
            rem[prev]--;
            for (int k = 1; k < nwr; k++) begin
                int c, e;
                c = int'(log_addr[k] >> 12) - 1;
                e = -1;
                for (int j = 1; j <= 4; j++)
                    if (e < 0 && rem[(prev + j) % 4] > 0) e = (prev + j) % 4;
                if (k >= 3 && c != e) bad++;
                if (c >= 0 && c < 4) rem[c]--;
                prev = c;
            end
            check(bad == 0, "R8 round-robin order", 32'(bad), 32'd0);
        end

        // R8: pointer moves past the served channel
        do_reset();
        setup(0, 32'h100, 32'h1000, 32'd1, 32'd1);
        setup(1, 32'h100, 32'h2000, 32'd1, 32'd2);
        setup(3, 32'h100, 32'h4000, 32'd1, 32'd1);
        nwr = 0;
        wr_hold = 1;
        cfg_wr(1, 4, 32'h9);
        repeat (6) @(negedge clk);
        cfg_wr(0, 4, 32'h9); cfg_wr(3, 4, 32'h9);
        wr_hold = 0;
        wait_off(0); wait_off(1); wait_off(3);
        check(nwr == 4 && log_addr[0] == 32'h2000 && log_addr[1] == 32'h4000 &&
              log_addr[2] == 32'h1000 && log_addr[3] == 32'h2004,
              "R8 pointer after served channel", log_addr[1], 32'h4000);

        // R6: loop rewinds, no done, stops on disable
        do_reset();
        setup(0, 32'h600, 32'h1000, 32'd1, 32'd2);
        nwr = 0;
        cfg_wr(0, 4, 32'h0000_000B);
        for (int i = 0; i < 200 && nwr < 5; i++) @(negedge clk);
        check(nwr >= 5 && log_addr[2] == 32'h1000 && log_addr[3] == 32'h1004 &&
              log_data[4] == mem_val(32'h600) && !done_o[0],
              "R6 loop rewind", log_addr[2], 32'h1000);
        cfg_wr(0, 4, 32'h0000_000A);
        begin
            int n0;
            n0 = nwr;
            repeat (30) @(negedge clk);
            cfg_rd(0, 5, s);
            check(nwr <= n0 + 1 && s[1:0] == 2'b00, "R6 disable stops loop",
                  32'(nwr - n0), 32'd1);
        end

        // R10: long latency and toggling ready
        do_reset();
        setup(2, 32'hA00, 32'h3000, 32'd1, 32'd3);
        stall = 1; lat_extra = 5;
        nwr = 0;
        cfg_wr(2, 4, 32'h9);
        wait_off(2);
        check(nwr == 3 && log_addr[0] == 32'h3000 && log_data[1] == mem_val(32'hA04) &&
              log_addr[2] == 32'h3008 && log_data[2] == mem_val(32'hA08),
              "R10 latency and back-pressure", log_data[2], mem_val(32'hA08));
        stall = 0; lat_extra = 0;

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule